// File: doc/BRIEF.md
# DAC Data Register Transfer Controller

This block is the digital front end of one 12-bit converter channel. Register-bus writes arrive in one of three alignment formats. Each write is shifted into a single internal 12-bit holding register. The held value is then copied into an output code register that feeds the analog converter. The bus has no path that writes the output register directly.

With trigger mode off, every accepted write reaches the output one cycle after the holding register takes it. With trigger mode on, writes only refresh the holding register. The copy runs three cycles after a trigger event. The event comes from one of seven external lines, selected by a 3-bit source code, or from a self-clearing software trigger bit. A one-cycle strobe marks every update of the output code.

The channel enable bit only drives the analog power-up output. The register datapath and the transfer logic run the same way whether that bit is set or clear.

Top module: `dac_xfer_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `dac_code` is 0, `dac_load` is 0, `sw_trig_busy` is 0 and `analog_en` is 0, and both trigger mode and trigger select are 0.
- R2: A write with `wr_fmt` = 2'b00 (12-bit right aligned) stores `wr_data[11:0]` in the holding register.
- R3: A write with `wr_fmt` = 2'b01 (12-bit left aligned) stores `wr_data[15:4]` in the holding register.
- R4: A write with `wr_fmt` = 2'b10 (8-bit right aligned) stores `wr_data[7:0]` in holding bits [11:4] and clears holding bits [3:0].
- R5: A write with `wr_fmt` = 2'b11 is ignored: the holding register is unchanged and no transfer starts.
- R6: With trigger mode off, a write sampled at clock edge N updates `dac_code` at edge N+1. Writes on consecutive cycles produce loads on consecutive cycles.
- R7: With trigger mode on, writes do not change `dac_code`. A trigger event sampled at edge T copies the holding register to `dac_code` at edge T+3.
- R8: A trigger select value from 0 to 6 picks `ext_trig[sel]`. Only a rising edge of that line is an event: a line held high raises no further events, and the unselected lines are ignored.
- R9: A trigger select value of 7 picks the software trigger. A `sw_trig_set` pulse sets `sw_trig_busy` on the next edge. Once trigger mode is on, the event is taken one edge later. `sw_trig_busy` clears on the edge at which the transfer it started loads `dac_code`.
- R10: A trigger event that arrives while a triggered transfer is still pending is ignored and does not restart the countdown.
- R11: `analog_en` follows the channel enable bit written through the configuration port, and a clear enable bit has no effect on writes or transfers.
- R12: `dac_load` is high for exactly one cycle per update of `dac_code`, and `dac_code` never changes while `dac_load` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Data write strobe |
| wr_fmt | input | 2 | Write alignment: 00 right-12, 01 left-12, 10 right-8, 11 reserved |
| wr_data | input | 16 | Bus write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan_en | input | 1 | Channel (analog) enable value |
| cfg_trig_en | input | 1 | Trigger mode enable value |
| cfg_trig_sel | input | 3 | Trigger source: 0..6 external line, 7 software |
| sw_trig_set | input | 1 | Write-one pulse that sets the software trigger bit |
| ext_trig | input | 7 | External trigger lines, synchronous to clk |
| analog_en | output | 1 | Registered channel enable for the analog macrocell |
| sw_trig_busy | output | 1 | Software trigger bit |
| dac_code | output | 12 | Output code register |
| dac_load | output | 1 | One-cycle strobe on each output update |

## Verification
The embedded properties assume that the external trigger lines are already synchronous to `clk`. They also assume that the trigger select and trigger mode stay unchanged while a line edge or a pending transfer is in flight. The level-hold property additionally needs the select to be stable for a cycle before it speaks about a held line. The stimulus changes configuration only while the datapath is idle and every trigger line is low. It moves the external lines only on the falling clock edge. It never writes the holding register during a triggered countdown, so each expected output code is fixed at the moment the trigger is driven.

// File: rtl/dacfe_pkg.sv
// Shared definitions for the converter-channel front end.
// Assumes: the write-format encoding below is fixed by the bus register layout.
package dacfe_pkg;

    // Alignment of a bus write into the holding register.
    typedef enum logic [1:0] {
        FMT_R12 = 2'b00,
        FMT_L12 = 2'b01,
        FMT_R8  = 2'b10,
        FMT_RSV = 2'b11
    } wr_fmt_e;

endpackage

// File: rtl/dac_hold_align.sv
// Aligns a bus write into the holding register according to its format and
// raises a one-cycle update flag the cycle after a write is accepted.
// Assumes: BUS_W >= DATA_W > BYTE_W; reserved-format writes are dropped.
module dac_hold_align
    import dacfe_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_fmt,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [DATA_W-1:0] hold,
    output logic              hold_upd
);

    localparam int PAD_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] aligned;
    logic              fmt_ok;

    // Shift the bus word into holding-register alignment.
    always_comb begin
        aligned = '0;
        fmt_ok  = 1'b1;
        case (wr_fmt)
            FMT_R12: aligned = wr_data[DATA_W-1:0];
            FMT_L12: aligned = wr_data[BUS_W-1 -: DATA_W];
            FMT_R8:  aligned = {wr_data[BYTE_W-1:0], {PAD_W{1'b0}}};
            default: fmt_ok  = 1'b0;
        endcase
    end

    // Holding register and its update flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold     <= '0;
            hold_upd <= 1'b0;
        end else begin
            hold_upd <= wr_en && fmt_ok;
            if (wr_en && fmt_ok) begin
                hold <= aligned;
            end
        end
    end

    // R5
    rsv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fmt == FMT_RSV) |=> ($stable(hold) && !hold_upd));

    // R2
    right12_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fmt == FMT_R12) |=> (hold == $past(wr_data[DATA_W-1:0])));

    // R4
    right8_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fmt == FMT_R8) |=> (hold[PAD_W-1:0] == '0));

endmodule

// File: rtl/dac_trig_sel.sv
// Selects the trigger source, detects rising edges on external lines and
// keeps the self-clearing software trigger bit.
// Assumes: external lines are synchronous to clk; NUM_EXT < 2**SEL_W, and
// the top select code names the software trigger.
module dac_trig_sel #(
    parameter int NUM_EXT = 7,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_en,
    input  logic [SEL_W-1:0]   trig_sel,
    input  logic [NUM_EXT-1:0] ext_trig,
    input  logic               sw_trig_set,
    input  logic               xfer_busy,
    input  logic               xfer_done,
    output logic               trig_evt,
    output logic               sw_flag
);

    localparam int                NSRC    = 2 ** SEL_W;
    localparam logic [SEL_W-1:0]  SW_CODE = SEL_W'(NSRC - 1);

    logic [NUM_EXT-1:0] ext_prev;
    logic [NUM_EXT-1:0] ext_rise;
    logic [NSRC-1:0]    src;
    logic [NSRC-1:0]    ext_pad;
    logic               sw_owned;

    assign ext_rise = ext_trig & ~ext_prev;

    // Map every select code onto a source: lines, unused codes, software bit.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i < NUM_EXT) begin : g_ext
            assign src[i]     = ext_rise[i];
            assign ext_pad[i] = ext_trig[i];
        end else if (i == NSRC - 1) begin : g_sw
            assign src[i]     = sw_flag;
            assign ext_pad[i] = 1'b0;
        end else begin : g_none
            assign src[i]     = 1'b0;
            assign ext_pad[i] = 1'b0;
        end
    end

    // Accept an event only in trigger mode and with no transfer pending.
    assign trig_evt = trig_en && !xfer_busy && src[trig_sel];

    // Remember last line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_prev <= '0;
        end else begin
            ext_prev <= ext_trig;
        end
    end

    // Software trigger bit: set by write-one, cleared when its transfer lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_flag  <= 1'b0;
            sw_owned <= 1'b0;
        end else begin
            if (trig_evt && trig_sel == SW_CODE) begin
                sw_owned <= 1'b1;
            end else if (xfer_done) begin
                sw_owned <= 1'b0;
            end
            if (sw_trig_set) begin
                sw_flag <= 1'b1;
            end else if (xfer_done && sw_owned) begin
                sw_flag <= 1'b0;
            end
        end
    end

    // R9
    sw_set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_trig_set |=> sw_flag);

    // R8
    ext_level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_evt && trig_sel != SW_CODE) |-> ext_pad[trig_sel]);

    // R8
    held_level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel != SW_CODE && $stable(trig_sel) && $stable(ext_pad)) |-> !trig_evt);

endmodule

// File: rtl/dac_xfer_seq.sv
// Moves the holding register into the output code register, either one
// cycle after a write (trigger mode off) or a fixed latency after an
// accepted trigger event (trigger mode on), with a one-cycle load strobe.
// Assumes: LAT >= 1; events are only offered when the countdown is idle.
module dac_xfer_seq #(
    parameter int DATA_W = 12,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_en,
    input  logic [DATA_W-1:0] hold,
    input  logic              hold_upd,
    input  logic              trig_evt,
    output logic              xfer_busy,
    output logic              xfer_done,
    output logic [DATA_W-1:0] dout,
    output logic              dout_load
);

    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt;
    logic             load_now;

    assign xfer_busy = (cnt != '0);
    assign xfer_done = (cnt == CNT_W'(1));
    assign load_now  = xfer_done || (hold_upd && !trig_en);

    // Countdown of the triggered transfer latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (xfer_busy) begin
            cnt <= cnt - CNT_W'(1);
        end else if (trig_evt) begin
            cnt <= CNT_W'(LAT);
        end
    end

    // Output code register and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout      <= '0;
            dout_load <= 1'b0;
        end else begin
            dout_load <= load_now;
            if (load_now) begin
                dout <= hold;
            end
        end
    end

    // R12
    quiet_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_load |-> $stable(dout));

    // R6
    direct_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_upd && !trig_en) |=> (dout_load && dout == $past(hold)));

    // R7
    trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_evt && !xfer_busy) |=> (cnt == CNT_W'(LAT)));

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/dac_xfer_ctrl.sv
// Top of the converter-channel front end: configuration register, format
// alignment, trigger selection and output transfer sequencing.
// Assumes: all inputs are synchronous to clk; configuration is changed
// only while no transfer is pending.
module dac_xfer_ctrl #(
    parameter int DATA_W  = 12,
    parameter int BUS_W   = 16,
    parameter int BYTE_W  = 8,
    parameter int NUM_EXT = 7,
    parameter int SEL_W   = 3,
    parameter int LAT     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_fmt,
    input  logic [BUS_W-1:0]   wr_data,
    input  logic               cfg_we,
    input  logic               cfg_chan_en,
    input  logic               cfg_trig_en,
    input  logic [SEL_W-1:0]   cfg_trig_sel,
    input  logic               sw_trig_set,
    input  logic [NUM_EXT-1:0] ext_trig,
    output logic               analog_en,
    output logic               sw_trig_busy,
    output logic [DATA_W-1:0]  dac_code,
    output logic               dac_load
);

    logic              trig_en_q;
    logic [SEL_W-1:0]  trig_sel_q;
    logic [DATA_W-1:0] hold;
    logic              hold_upd;
    logic              trig_evt;
    logic              xfer_busy;
    logic              xfer_done;

    // Configuration register written through the control port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            analog_en  <= 1'b0;
            trig_en_q  <= 1'b0;
            trig_sel_q <= '0;
        end else if (cfg_we) begin
            analog_en  <= cfg_chan_en;
            trig_en_q  <= cfg_trig_en;
            trig_sel_q <= cfg_trig_sel;
        end
    end

    dac_hold_align #(
        .DATA_W (DATA_W),
        .BUS_W  (BUS_W),
        .BYTE_W (BYTE_W)
    ) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_fmt   (wr_fmt),
        .wr_data  (wr_data),
        .hold     (hold),
        .hold_upd (hold_upd)
    );

    dac_trig_sel #(
        .NUM_EXT (NUM_EXT),
        .SEL_W   (SEL_W)
    ) u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_en     (trig_en_q),
        .trig_sel    (trig_sel_q),
        .ext_trig    (ext_trig),
        .sw_trig_set (sw_trig_set),
        .xfer_busy   (xfer_busy),
        .xfer_done   (xfer_done),
        .trig_evt    (trig_evt),
        .sw_flag     (sw_trig_busy)
    );

    dac_xfer_seq #(
        .DATA_W (DATA_W),
        .LAT    (LAT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_en   (trig_en_q),
        .hold      (hold),
        .hold_upd  (hold_upd),
        .trig_evt  (trig_evt),
        .xfer_busy (xfer_busy),
        .xfer_done (xfer_done),
        .dout      (dac_code),
        .dout_load (dac_load)
    );

    // R11
    enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (analog_en == $past(cfg_chan_en)));

    // R7
    trig_mode_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en_q && !xfer_busy) |=> !dac_load);

endmodule

// File: tb/dac_xfer_ctrl_test.sv
// Scoreboard bench: driver tasks queue the expected load cycle and code,
// a monitor on the falling edge pops and compares every load it sees.
module dac_xfer_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_fmt = 2'b00;
    logic [15:0] wr_data = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_chan_en = 1'b0;
    logic        cfg_trig_en = 1'b0;
    logic [2:0]  cfg_trig_sel = '0;
    logic        sw_trig_set = 1'b0;
    logic [6:0]  ext_trig = '0;
    logic        analog_en;
    logic        sw_trig_busy;
    logic [11:0] dac_code;
    logic        dac_load;

    typedef struct {
        int          cyc;
        logic [11:0] code;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [11:0] last_code = '0;
    bit          done = 1'b0;

    dac_xfer_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_fmt       (wr_fmt),
        .wr_data      (wr_data),
        .cfg_we       (cfg_we),
        .cfg_chan_en  (cfg_chan_en),
        .cfg_trig_en  (cfg_trig_en),
        .cfg_trig_sel (cfg_trig_sel),
        .sw_trig_set  (sw_trig_set),
        .ext_trig     (ext_trig),
        .analog_en    (analog_en),
        .sw_trig_busy (sw_trig_busy),
        .dac_code     (dac_code),
        .dac_load     (dac_load)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every strobe must match the head of the queue in cycle and code.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dac_load) begin
                if (q.size() == 0) begin
                    check(1'b0, "R12 unexpected load", int'(dac_code), 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(dac_code == e.code, {e.tag, " code"}, int'(dac_code), int'(e.code));
                    check(cyc == e.cyc, {e.tag, " cycle"}, cyc, e.cyc);
                end
            end else if (dac_code !== last_code) begin
                check(1'b0, "R12 code changed without strobe", int'(dac_code), int'(last_code));
            end
            last_code = dac_code;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic [1:0] f, input logic [15:0] d,
                         input bit exp_load, input logic [11:0] exp_code, input string tag);
        wr_en = 1'b1; wr_fmt = f; wr_data = d;
        if (exp_load) q.push_back('{cyc + 2, exp_code, tag});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(input bit ch, input bit te, input logic [2:0] sel);
        cfg_we = 1'b1; cfg_chan_en = ch; cfg_trig_en = te; cfg_trig_sel = sel;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ext_set(input int line, input bit v,
                           input bit exp_load, input logic [11:0] exp_code, input string tag);
        ext_trig[line] = v;
        if (exp_load) q.push_back('{cyc + 4, exp_code, tag});
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dac_code == 12'h000, "R1 code", int'(dac_code), 0);
        check(dac_load == 1'b0, "R1 load", int'(dac_load), 0);
        check(sw_trig_busy == 1'b0, "R1 busy", int'(sw_trig_busy), 0);
        check(analog_en == 1'b0, "R1 enable", int'(analog_en), 0);
        rst_n = 1'b1;
        tick(2);

        // Untriggered writes in each format
        write(2'b00, 16'hFABC, 1'b1, 12'hABC, "R2");
        tick(2);
        write(2'b01, 16'h5A3F, 1'b1, 12'h5A3, "R3");
        tick(2);
        write(2'b10, 16'hFF7E, 1'b1, 12'h7E0, "R4");
        tick(2);
        write(2'b11, 16'h1234, 1'b0, 12'h000, "R5");
        tick(4);
        check(dac_code == 12'h7E0, "R5 reserved ignored", int'(dac_code), 'h7E0);

        // Enable bit and back-to-back writes
        cfg(1'b1, 1'b0, 3'd0);
        check(analog_en == 1'b1, "R11 enable set", int'(analog_en), 1);
        write(2'b00, 16'h0111, 1'b1, 12'h111, "R6 first");
        write(2'b00, 16'h0222, 1'b1, 12'h222, "R6 second");
        tick(3);
        cfg(1'b0, 1'b0, 3'd0);
        check(analog_en == 1'b0, "R11 enable clear", int'(analog_en), 0);
        write(2'b00, 16'h00F0, 1'b1, 12'h0F0, "R11 disabled path");
        tick(3);

        // Trigger mode on external line 2
        cfg(1'b1, 1'b1, 3'd2);
        write(2'b00, 16'h0333, 1'b0, 12'h000, "R7");
        tick(5);
        check(dac_code == 12'h0F0, "R7 write held", int'(dac_code), 'h0F0);
        ext_set(4, 1'b1, 1'b0, 12'h000, "R8");
        tick(6);
        check(dac_code == 12'h0F0, "R8 other line ignored", int'(dac_code), 'h0F0);
        ext_set(4, 1'b0, 1'b0, 12'h000, "R8");
        ext_set(2, 1'b1, 1'b1, 12'h333, "R7 triggered copy");
        tick(10);
        check(dac_code == 12'h333, "R8 level hold no retrigger", int'(dac_code), 'h333);
        ext_set(2, 1'b0, 1'b0, 12'h000, "R8");
        tick(2);

        // Second edge during the pending window
        write(2'b00, 16'h0444, 1'b0, 12'h000, "R10");
        tick(1);
        ext_set(2, 1'b1, 1'b1, 12'h444, "R10 first edge");
        ext_set(2, 1'b0, 1'b0, 12'h000, "R10");
        ext_set(2, 1'b1, 1'b0, 12'h000, "R10");
        ext_set(2, 1'b0, 1'b0, 12'h000, "R10");
        tick(6);
        write(2'b00, 16'h0445, 1'b0, 12'h000, "R10");
        tick(1);
        ext_set(2, 1'b1, 1'b1, 12'h445, "R10 later edge");
        ext_set(2, 1'b0, 1'b0, 12'h000, "R10");
        tick(6);

        // Software trigger
        cfg(1'b1, 1'b1, 3'd7);
        write(2'b00, 16'h0555, 1'b0, 12'h000, "R9");
        ext_set(2, 1'b1, 1'b0, 12'h000, "R8");
        tick(6);
        check(dac_code == 12'h445, "R8 line ignored under software select", int'(dac_code), 'h445);
        ext_set(2, 1'b0, 1'b0, 12'h000, "R8");
        sw_trig_set = 1'b1;
        q.push_back('{cyc + 5, 12'h555, "R9 software copy"});
        @(negedge clk);
        sw_trig_set = 1'b0;
        check(sw_trig_busy == 1'b1, "R9 busy set", int'(sw_trig_busy), 1);
        tick(3);
        check(sw_trig_busy == 1'b1, "R9 busy held", int'(sw_trig_busy), 1);
        tick(1);
        check(sw_trig_busy == 1'b0, "R9 busy cleared", int'(sw_trig_busy), 0);
        tick(8);

        check(q.size() == 0, "R12 missing loads", q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule